// File: doc/BRIEF.md
# Five-Point Stencil Tile Engine

The engine advances a two-dimensional diffusion grid by one explicit time step, three by three output points at a time. Each new point is a weighted sum of five values from the previous step: the pair one row above and below, weighted by the row coefficient; the pair one column left and right, weighted by the column coefficient; and the point itself, weighted by the centre coefficient. Values and coefficients are 16-bit signed fixed point with 8 fraction bits. A tile needs 21 distinct grid values and yields 9 results, so seven operations per point give 63 per tile.

The grid values reach the block as two strips on two valid/ready streams. Stream A carries a strip five rows tall and three columns wide: rows i-1 to i+3 over columns j to j+2, row-major. Stream B carries a strip three rows tall and five columns wide: rows i to i+2 over columns j-1 to j+3, row-major. The nine tile values appear in both strips; the engine takes them from stream A and uses only the two outer columns of stream B. Each stream has two strip banks, so the next tile fills while the current one is evaluated and sent. The nine results leave, row-major, on one valid/ready stream with a last-word flag. Coefficients are loaded through a small write port while the engine holds no data. The caller moves the tile origin by three in each dimension and supplies the border values itself.

The result stage is a two-state machine. In `SER_EMPTY` it holds no results. The transition `load` moves it to `SER_SEND` when both streams hold a complete strip. It returns to `SER_EMPTY` through the transition `drain`, which is the accepted ninth word. Each strip bank is either `BANK_FREE` or `BANK_HELD`. It moves to held (transition `fill`) when its fifteenth word is accepted, and back to free (transition `pop`) when its tile is loaded into the result stage.

Top module: `stencil_tile_engine`

## Requirements
- R1: After reset, `r_valid` and `r_last` are 0, `a_ready` and `b_ready` are 1, and `cfg_err` is 0.
- R2: A write with `cfg_we` high while the engine is idle stores `cfg_data` into the coefficient chosen by `cfg_sel`: 0 selects the row coefficient, 1 the column coefficient and 2 the centre coefficient. Code 3 changes nothing.
- R3: A coefficient write while the engine holds any input word or unsent result is ignored and sets `cfg_err`, which stays 1 until reset.
- R4: For a tile point at row r and column c (0..2), the up, centre and down values are stream A words r*3+c, (r+1)*3+c and (r+2)*3+c. The left value is stream A word (r+1)*3+c-1, or stream B word r*5 when c is 0. The right value is stream A word (r+1)*3+c+1, or stream B word r*5+4 when c is 2. Stream B words r*5+1 to r*5+3 have no effect on any result.
- R5: Each result is row_coef*(up+down) + col_coef*(left+right) + centre_coef*centre, with all operands read as signed Q8.8.
- R6: The full-precision sum has 16 fraction bits. It is rounded to 8 fraction bits by adding 128 and shifting right arithmetically by 8, so halves round toward plus infinity.
- R7: A rounded value above 32767 is sent as 0x7FFF, and one below -32768 is sent as 0x8000.
- R8: The nine results of a tile leave in row-major order, (0,0), (0,1), (0,2), (1,0) and so on, and `r_last` is 1 on the ninth word only.
- R9: While `r_valid` is 1 and `r_ready` is 0, `r_valid`, `r_data` and `r_last` hold their values into the next cycle.
- R10: A stream keeps accepting the next strip while the earlier strip waits for its partner. It drops its ready only when it holds two complete strips.
- R11: Tiles leave in the order their strips arrived. The nth strip on A is always paired with the nth strip on B.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_sel | input | 2 | Coefficient select: 0 row, 1 column, 2 centre |
| cfg_data | input | 16 | Coefficient value, signed Q8.8 |
| cfg_err | output | 1 | Sticky flag: write attempted while busy |
| a_valid | input | 1 | Stream A word valid |
| a_data | input | 16 | Stream A word, signed Q8.8 |
| a_ready | output | 1 | Stream A can accept a word |
| b_valid | input | 1 | Stream B word valid |
| b_data | input | 16 | Stream B word, signed Q8.8 |
| b_ready | output | 1 | Stream B can accept a word |
| r_valid | output | 1 | Result word valid |
| r_data | output | 16 | Result word, signed Q8.8 |
| r_last | output | 1 | Ninth word of a tile |
| r_ready | input | 1 | Consumer accepts the result word |

## Verification
Two functions can land on the same clock edge. One is a strip's last word, which sets one bank to held. The other is the `load` transition, which frees the other bank of that stream. The two act on different banks, so neither may disturb the other. The bench provokes this edge by sending tiles back to back while the output is throttled to one word in three. It also sends two strips on stream A before any arrive on B. It judges the outcome by checking every result word against the arithmetic reference, in arrival order. A lost or duplicated bank update would shift, pair wrongly or drop a tile.

// File: rtl/stile_pkg.sv
package stile_pkg;

    typedef enum logic [1:0] {
        COEF_ROW = 2'd0,
        COEF_COL = 2'd1,
        COEF_MID = 2'd2,
        COEF_NONE = 2'd3
    } coef_sel_e;

    typedef enum logic {
        BANK_FREE = 1'b0,
        BANK_HELD = 1'b1
    } bank_state_e;

    typedef enum logic {
        SER_EMPTY = 1'b0,
        SER_SEND  = 1'b1
    } ser_state_e;

endpackage

// File: rtl/strip_buffer.sv
module strip_buffer
    import stile_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int ROWS      = 5,
    parameter int COLS      = 3,
    parameter bit EDGE_ONLY = 1'b0
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      in_valid,
    input  logic [DATA_W-1:0]         in_data,
    output logic                      in_ready,
    output logic                      out_valid,
    output logic [OUT_N*DATA_W-1:0]   out_words,
    input  logic                      pop,
    output logic                      buf_idle
);
    localparam int WORDS = ROWS * COLS;
    localparam int OUT_N = EDGE_ONLY ? 2 * ROWS : WORDS;
    localparam int IDX_W = $clog2(WORDS);

    logic [DATA_W-1:0] mem [2][WORDS];
    bank_state_e       bank_st [2];
    logic              wr_bank;
    logic              rd_bank;
    logic [IDX_W-1:0]  wr_idx;
    logic              take;
    logic              strip_done;

    assign take       = in_valid && in_ready;
    assign strip_done = take && (wr_idx == IDX_W'(WORDS - 1));

    always_ff @(posedge clk) begin
        if (take) begin
            mem[wr_bank][wr_idx] <= in_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_st[0] <= BANK_FREE;
            bank_st[1] <= BANK_FREE;
            wr_bank    <= 1'b0;
            rd_bank    <= 1'b0;
            wr_idx     <= '0;
        end else begin
            if (take) begin
                if (strip_done) begin
                    wr_idx           <= '0;
                    bank_st[wr_bank] <= BANK_HELD;
                    wr_bank          <= ~wr_bank;
                end else begin
                    wr_idx <= wr_idx + 1'b1;
                end
            end
            if (pop) begin
                bank_st[rd_bank] <= BANK_FREE;
                rd_bank          <= ~rd_bank;
            end
        end
    end

    assign in_ready  = (bank_st[wr_bank] == BANK_FREE);
    assign out_valid = (bank_st[rd_bank] == BANK_HELD);
    assign buf_idle  = (bank_st[0] == BANK_FREE) && (bank_st[1] == BANK_FREE)
                       && (wr_idx == '0);

    generate
        if (EDGE_ONLY) begin : g_edge
            for (genvar r = 0; r < ROWS; r++) begin : g_row
                assign out_words[(2*r)*DATA_W +: DATA_W]   = mem[rd_bank][r*COLS];
                assign out_words[(2*r+1)*DATA_W +: DATA_W] = mem[rd_bank][r*COLS + COLS - 1];
            end
        end else begin : g_full
            for (genvar k = 0; k < WORDS; k++) begin : g_word
                assign out_words[k*DATA_W +: DATA_W] = mem[rd_bank][k];
            end
        end
    endgenerate

    // R10
    both_held_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_st[0] == BANK_HELD && bank_st[1] == BANK_HELD) |-> !in_ready);

    // R11
    pop_needs_strip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> out_valid);

    // R11
    fill_then_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strip_done |=> (bank_st[$past(wr_bank)] == BANK_HELD));

endmodule

// File: rtl/stencil_core.sv
module stencil_core #(
    parameter int DATA_W   = 16,
    parameter int FRAC_W   = 8,
    parameter int TILE_DIM = 3
) (
    input  logic [(TILE_DIM+2)*TILE_DIM*DATA_W-1:0] a_words,
    input  logic [2*TILE_DIM*DATA_W-1:0]            b_edges,
    input  logic [DATA_W-1:0]                       c_row,
    input  logic [DATA_W-1:0]                       c_col,
    input  logic [DATA_W-1:0]                       c_mid,
    output logic [TILE_DIM*TILE_DIM*DATA_W-1:0]     res_words
);
    localparam int T      = TILE_DIM;
    localparam int SUM_W  = DATA_W + 1;
    localparam int PROD_W = SUM_W + DATA_W;
    localparam int ACC_W  = PROD_W + 2;
    localparam logic signed [ACC_W-1:0] HALF = ACC_W'(1) <<< (FRAC_W - 1);
    localparam logic signed [ACC_W-1:0] MAXV = (ACC_W'(1) <<< (DATA_W - 1)) - ACC_W'(1);
    localparam logic signed [ACC_W-1:0] MINV = -(ACC_W'(1) <<< (DATA_W - 1));

    generate
        for (genvar r = 0; r < T; r++) begin : g_row
            for (genvar c = 0; c < T; c++) begin : g_col
                logic signed [DATA_W-1:0] up_v, dn_v, lf_v, rt_v, ctr_v;
                logic signed [SUM_W-1:0]  vert_s, horz_s;
                logic signed [PROD_W-1:0] vert_p, horz_p, mid_p;
                logic signed [ACC_W-1:0]  acc, rnd;

                assign up_v  = $signed(a_words[(r*T + c)*DATA_W +: DATA_W]);
                assign ctr_v = $signed(a_words[((r+1)*T + c)*DATA_W +: DATA_W]);
                assign dn_v  = $signed(a_words[((r+2)*T + c)*DATA_W +: DATA_W]);

                if (c == 0) begin : g_lf_edge
                    assign lf_v = $signed(b_edges[(2*r)*DATA_W +: DATA_W]);
                end else begin : g_lf_in
                    assign lf_v = $signed(a_words[((r+1)*T + c - 1)*DATA_W +: DATA_W]);
                end

                if (c == T - 1) begin : g_rt_edge
                    assign rt_v = $signed(b_edges[(2*r+1)*DATA_W +: DATA_W]);
                end else begin : g_rt_in
                    assign rt_v = $signed(a_words[((r+1)*T + c + 1)*DATA_W +: DATA_W]);
                end

                always_comb begin
                    vert_s = SUM_W'(up_v) + SUM_W'(dn_v);
                    horz_s = SUM_W'(lf_v) + SUM_W'(rt_v);
                    vert_p = PROD_W'(vert_s) * PROD_W'($signed(c_row));
                    horz_p = PROD_W'(horz_s) * PROD_W'($signed(c_col));
                    mid_p  = PROD_W'(ctr_v)  * PROD_W'($signed(c_mid));
                    acc    = ACC_W'(vert_p) + ACC_W'(horz_p) + ACC_W'(mid_p);
                    rnd    = (acc + HALF) >>> FRAC_W;
                    if (rnd > MAXV) begin
                        res_words[(r*T + c)*DATA_W +: DATA_W] = MAXV[DATA_W-1:0];
                    end else if (rnd < MINV) begin
                        res_words[(r*T + c)*DATA_W +: DATA_W] = MINV[DATA_W-1:0];
                    end else begin
                        res_words[(r*T + c)*DATA_W +: DATA_W] = rnd[DATA_W-1:0];
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/result_serializer.sv
module result_serializer
    import stile_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int POINTS = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic [POINTS*DATA_W-1:0] load_words,
    input  logic                     out_ready,
    output logic                     out_valid,
    output logic [DATA_W-1:0]        out_data,
    output logic                     out_last,
    output logic                     empty
);
    localparam int CNT_W = $clog2(POINTS);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(POINTS - 1);

    ser_state_e        state, state_nx;
    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] words [POINTS];
    logic              sent;

    assign sent = (state == SER_SEND) && out_ready;

    always_comb begin
        state_nx = state;
        unique case (state)
            SER_EMPTY: if (load) state_nx = SER_SEND;
            SER_SEND:  if (sent && cnt == LAST_IDX) state_nx = SER_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SER_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            if (load) begin
                cnt <= '0;
            end else if (sent) begin
                cnt <= (cnt == LAST_IDX) ? '0 : cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (load) begin
            for (int k = 0; k < POINTS; k++) begin
                words[k] <= load_words[k*DATA_W +: DATA_W];
            end
        end
    end

    always_comb begin
        out_valid = 1'b0;
        out_last  = 1'b0;
        empty     = 1'b0;
        out_data  = words[cnt];
        unique case (state)
            SER_EMPTY: empty = 1'b1;
            SER_SEND: begin
                out_valid = 1'b1;
                out_last  = (cnt == LAST_IDX);
            end
        endcase
    end

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R8
    last_ends_tile_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !out_valid);

    // R11
    load_into_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> empty);

endmodule

// File: rtl/stencil_tile_engine.sv
module stencil_tile_engine
    import stile_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int FRAC_W   = 8,
    parameter int TILE_DIM = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_data,
    output logic              cfg_err,
    input  logic              a_valid,
    input  logic [DATA_W-1:0] a_data,
    output logic              a_ready,
    input  logic              b_valid,
    input  logic [DATA_W-1:0] b_data,
    output logic              b_ready,
    output logic              r_valid,
    output logic [DATA_W-1:0] r_data,
    output logic              r_last,
    input  logic              r_ready
);
    localparam int A_N    = (TILE_DIM + 2) * TILE_DIM;
    localparam int B_N    = 2 * TILE_DIM;
    localparam int POINTS = TILE_DIM * TILE_DIM;

    logic [A_N*DATA_W-1:0]    a_words;
    logic [B_N*DATA_W-1:0]    b_edges;
    logic [POINTS*DATA_W-1:0] res_words;
    logic                     a_full, b_full, a_idle, b_idle;
    logic                     ser_empty, tile_load, busy;
    logic [DATA_W-1:0]        c_row, c_col, c_mid;

    assign tile_load = a_full && b_full && ser_empty;
    assign busy      = !(a_idle && b_idle && ser_empty);

    strip_buffer #(
        .DATA_W(DATA_W), .ROWS(TILE_DIM + 2), .COLS(TILE_DIM), .EDGE_ONLY(1'b0)
    ) u_strip_a (
        .clk(clk), .rst_n(rst_n),
        .in_valid(a_valid), .in_data(a_data), .in_ready(a_ready),
        .out_valid(a_full), .out_words(a_words),
        .pop(tile_load), .buf_idle(a_idle)
    );

    strip_buffer #(
        .DATA_W(DATA_W), .ROWS(TILE_DIM), .COLS(TILE_DIM + 2), .EDGE_ONLY(1'b1)
    ) u_strip_b (
        .clk(clk), .rst_n(rst_n),
        .in_valid(b_valid), .in_data(b_data), .in_ready(b_ready),
        .out_valid(b_full), .out_words(b_edges),
        .pop(tile_load), .buf_idle(b_idle)
    );

    stencil_core #(
        .DATA_W(DATA_W), .FRAC_W(FRAC_W), .TILE_DIM(TILE_DIM)
    ) u_core (
        .a_words(a_words), .b_edges(b_edges),
        .c_row(c_row), .c_col(c_col), .c_mid(c_mid),
        .res_words(res_words)
    );

    result_serializer #(
        .DATA_W(DATA_W), .POINTS(POINTS)
    ) u_ser (
        .clk(clk), .rst_n(rst_n),
        .load(tile_load), .load_words(res_words),
        .out_ready(r_ready),
        .out_valid(r_valid), .out_data(r_data), .out_last(r_last),
        .empty(ser_empty)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_row   <= '0;
            c_col   <= '0;
            c_mid   <= '0;
            cfg_err <= 1'b0;
        end else if (cfg_we) begin
            if (busy) begin
                cfg_err <= 1'b1;
            end else begin
                unique case (coef_sel_e'(cfg_sel))
                    COEF_ROW:  c_row <= cfg_data;
                    COEF_COL:  c_col <= cfg_data;
                    COEF_MID:  c_mid <= cfg_data;
                    COEF_NONE: ;
                endcase
            end
        end
    end

    // R3
    busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && busy) |=> (cfg_err && $stable(c_row) && $stable(c_col) && $stable(c_mid)));

    // R3
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R11
    paired_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tile_load |=> !r_last);

endmodule

// File: tb/sim_stencil_tile_engine.sv
module sim_stencil_tile_engine;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_data = 16'd0;
    logic        cfg_err;
    logic        a_valid = 1'b0;
    logic [15:0] a_data = 16'd0;
    logic        a_ready;
    logic        b_valid = 1'b0;
    logic [15:0] b_data = 16'd0;
    logic        b_ready;
    logic        r_valid;
    logic [15:0] r_data;
    logic        r_last;
    logic        r_ready = 1'b1;

    int checks = 0;
    int errors = 0;
    int exp_q[$];
    int out_pos = 0;
    int bp_mode = 0;
    int cyc = 0;
    string cur_tag = "R5";
    bit [31:0] seed = 32'h1234_5678;
    int k0 = 0, k1 = 0, k2 = 0;

    always #10 clk = ~clk;

    stencil_tile_engine u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cfg_err(cfg_err),
        .a_valid(a_valid), .a_data(a_data), .a_ready(a_ready),
        .b_valid(b_valid), .b_data(b_data), .b_ready(b_ready),
        .r_valid(r_valid), .r_data(r_data), .r_last(r_last), .r_ready(r_ready)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int rnd12();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return int'($signed(seed[27:16]));
    endfunction

    function automatic void push_expected(input int a[15], input int b[15]);
        for (int r = 0; r < 3; r++) begin
            for (int c = 0; c < 3; c++) begin
                longint up, dn, ct, lf, rt, acc, rv;
                up = a[r*3 + c];
                ct = a[(r+1)*3 + c];
                dn = a[(r+2)*3 + c];
                lf = (c == 0) ? b[r*5] : a[(r+1)*3 + c - 1];
                rt = (c == 2) ? b[r*5 + 4] : a[(r+1)*3 + c + 1];
                acc = longint'(k0) * (up + dn) + longint'(k1) * (lf + rt) + longint'(k2) * ct;
                rv = (acc + 128) >>> 8;
                if (rv > 32767) rv = 32767;
                if (rv < -32768) rv = -32768;
                exp_q.push_back(int'(rv));
            end
        end
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        a_valid = 1'b0;
        b_valid = 1'b0;
        cfg_we = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        out_pos = 0;
        k0 = 0; k1 = 0; k2 = 0;
        @(negedge clk);
    endtask

    task automatic write_cfg(input int sel, input int val);
        cfg_we = 1'b1;
        cfg_sel = 2'(sel);
        cfg_data = 16'(val);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_coefs(input int c0, input int c1, input int c2);
        write_cfg(0, c0);
        write_cfg(1, c1);
        write_cfg(2, c2);
        k0 = c0; k1 = c1; k2 = c2;
    endtask

    task automatic send_a(input int a[15]);
        for (int k = 0; k < 15; k++) begin
            a_valid = 1'b1;
            a_data = 16'(a[k]);
            while (!a_ready) @(negedge clk);
            @(negedge clk);
        end
        a_valid = 1'b0;
    endtask

    task automatic send_b(input int b[15]);
        for (int k = 0; k < 15; k++) begin
            b_valid = 1'b1;
            b_data = 16'(b[k]);
            while (!b_ready) @(negedge clk);
            @(negedge clk);
        end
        b_valid = 1'b0;
    endtask

    task automatic send_tile(input int a[15], input int b[15]);
        push_expected(a, b);
        fork
            send_a(a);
            send_b(b);
        join
    endtask

    task automatic fill_random(output int a[15], output int b[15]);
        for (int k = 0; k < 15; k++) begin
            a[k] = rnd12();
            b[k] = rnd12();
        end
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // Output monitor: decides r_ready and samples away from the rising edge
    initial begin
        bit stalled = 1'b0;
        int held = 0;
        forever begin
            @(negedge clk);
            cyc++;
            r_ready = (bp_mode == 0) ? 1'b1 : ((cyc % 3) == 0);
            if (stalled) begin
                // R9: stalled word must still be presented unchanged
                check(r_valid && (int'(r_data) == held), "R9", int'(r_data), held);
            end
            stalled = 1'b0;
            if (r_valid && rst_n) begin
                if (!r_ready) begin
                    stalled = 1'b1;
                    held = int'(r_data);
                end else begin
                    int expv;
                    expv = (exp_q.size() != 0) ? exp_q.pop_front() : 99999;
                    check(int'($signed(r_data)) == expv, cur_tag, int'($signed(r_data)), expv);
                    // R8: last flag only on the ninth word
                    check(r_last == (out_pos == 8), "R8", int'(r_last), int'(out_pos == 8));
                    out_pos = (out_pos == 8) ? 0 : out_pos + 1;
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int a[15];
        int b[15];
        int cset[6][3];
        cset = '{'{64, 64, 128}, '{256, 0, 0}, '{0, 256, 0}, '{0, 0, 256},
                 '{-64, 32, 384}, '{19, -77, 141}};

        do_reset();
        // R1
        check(r_valid == 1'b0, "R1", int'(r_valid), 0);
        check(r_last == 1'b0, "R1", int'(r_last), 0);
        check(a_ready && b_ready, "R1", int'(a_ready && b_ready), 1);
        check(cfg_err == 1'b0, "R1", int'(cfg_err), 0);

        // R5 / R2: sweep of coefficient sets, alternating output throttling
        for (int s = 0; s < 6; s++) begin
            cur_tag = "R5";
            set_coefs(cset[s][0], cset[s][1], cset[s][2]);
            bp_mode = s % 2;
            for (int t = 0; t < 4; t++) begin
                fill_random(a, b);
                send_tile(a, b);
            end
            drain();
        end
        check(cfg_err == 1'b0, "R2", int'(cfg_err), 0);

        // R2: select code 3 leaves every coefficient unchanged
        cur_tag = "R2";
        bp_mode = 0;
        write_cfg(3, 16'h7FFF);
        fill_random(a, b);
        send_tile(a, b);
        drain();

        // R4: outer-strip centre words carry extremes and must not matter
        cur_tag = "R4";
        set_coefs(100, 200, 300);
        fill_random(a, b);
        for (int r = 0; r < 3; r++) begin
            b[r*5+1] = 32767; b[r*5+2] = -32768; b[r*5+3] = 32767;
        end
        send_tile(a, b);
        drain();

        // R6: rounding of halves and near-halves through the centre term
        cur_tag = "R6";
        set_coefs(0, 0, 1);
        fill_random(a, b);
        a[3] = 128; a[4] = 127; a[5] = -128;
        a[6] = -129; a[7] = 384; a[8] = -384;
        a[9] = 383; a[10] = -127; a[11] = 0;
        send_tile(a, b);
        drain();

        // R7: saturation both ways
        cur_tag = "R7";
        set_coefs(32767, 32767, 32767);
        for (int k = 0; k < 15; k++) begin
            a[k] = (k < 9) ? 32767 : -32768;
            b[k] = (k < 5) ? 32767 : -32768;
        end
        send_tile(a, b);
        drain();

        // R10 / R11: two A strips before any B strip, throttled output
        cur_tag = "R11";
        set_coefs(77, -33, 201);
        bp_mode = 1;
        begin
            int a2[15];
            int b2[15];
            fill_random(a, b);
            fill_random(a2, b2);
            push_expected(a, b);
            push_expected(a2, b2);
            send_a(a);
            check(a_ready == 1'b1, "R10", int'(a_ready), 1);
            send_a(a2);
            check(a_ready == 1'b0, "R10", int'(a_ready), 0);
            check(r_valid == 1'b0, "R10", int'(r_valid), 0);
            send_b(b);
            send_b(b2);
            drain();
            check(a_ready && b_ready, "R10", int'(a_ready && b_ready), 1);
        end
        // back-to-back tiles under throttling
        for (int t = 0; t < 3; t++) begin
            fill_random(a, b);
            send_tile(a, b);
        end
        drain();

        // R3: write while busy is ignored and flagged
        cur_tag = "R3";
        bp_mode = 0;
        do_reset();
        set_coefs(40, 50, 60);
        fill_random(a, b);
        push_expected(a, b);
        send_a(a);
        write_cfg(0, 5000);
        check(cfg_err == 1'b1, "R3", int'(cfg_err), 1);
        send_b(b);
        drain();
        write_cfg(1, 50);
        check(cfg_err == 1'b1, "R3", int'(cfg_err), 1);
        check(exp_q.size() == 0, "R3", exp_q.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule